// File: doc/BRIEF.md
# Hardware Loop Controller

This block lets an in-order four-stage pipeline run counted loops with no increment, compare or branch instructions in the loop body. A short setup sequence stores each loop's first instruction address, last instruction address and trip count in a small table. The controller then watches the fetch program counter. Each time fetch presents the last address of a loop that still has passes left, it tells fetch to continue at the loop's first address and takes one off the count.

The table has two entries so that one loop can sit inside another. Entry 0 is the inner loop. When both loops end on the same instruction, entry 0 is served first. When an entry's final pass ends, the entry retires and fetch falls through. The redirect is combinational from the fetch PC, so it costs no bubble. Stalled fetch cycles are ignored.

Top module: `hwloop_ctrl`

## Requirements
- R1: After reset both entries are inactive and `redir_valid` stays low for any fetch PC.
- R2: A setup write selects a register with `cfg_sel`: 0 is the start address, 1 is the end address, 2 is the count, and 3 is ignored. `cfg_idx` picks the entry. Writing only the start and end addresses leaves an entry inactive.
- R3: Writing a count of zero leaves the entry inactive, so a later fetch of its end address does not redirect.
- R4: When the fetch PC equals an active entry's end address and its count is above one, `redir_valid` is high in that same cycle and `redir_pc` is that entry's start address.
- R5: Each redirect lowers that entry's count by one. A count of N gives N-1 redirects, so the body runs N times.
- R6: When the count is one at the end address, there is no redirect, the entry goes inactive, and later fetches of that address do not redirect.
- R7: While `fetch_stall` is high, `redir_valid` stays low and no count changes.
- R8: When both entries match the fetch PC and both have counts above one, entry 0's start address is the target and only entry 0's count changes.
- R9: When entry 0 retires on a shared end address, entry 1 acts in that same cycle: it redirects if its count is above one.
- R10: A fetch PC that matches no active end address gives no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Setup write strobe |
| cfg_idx | input | IDX_W | Table entry selected by the write |
| cfg_sel | input | 2 | Register select (0 start, 1 end, 2 count) |
| cfg_data | input | ADDR_W | Write data; the count uses the low CNT_W bits |
| fetch_pc | input | ADDR_W | Address fetch presents in this cycle |
| fetch_stall | input | 1 | Fetch is held; this cycle does not count |
| redir_valid | output | 1 | Fetch must continue at `redir_pc` |
| redir_pc | output | ADDR_W | Loop start address to fetch next |

## Verification
The assertions assume three things about the inputs:
- A fetch cycle that is not stalled presents each loop-end instruction once.
- Setup writes do not fall on the cycle in which the same entry is acting.
- The count fits in CNT_W bits.

The bench follows these rules. It does all setup writes before any loop runs, and drives fetch with exactly one PC value per clock. Every stalled cycle is released before the next fetch address is driven.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;
  typedef enum logic [1:0] {
    LREG_START = 2'd0,
    LREG_END   = 2'd1,
    LREG_COUNT = 2'd2
  } lreg_e;
endpackage

// File: rtl/hwloop_entry.sv
module hwloop_entry #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_start,
  input  logic              wr_end,
  input  logic              wr_cnt,
  input  logic [ADDR_W-1:0] wdata,
  input  logic [ADDR_W-1:0] pc,
  input  logic              take,
  output logic              hit,
  output logic              more,
  output logic [ADDR_W-1:0] start_addr
);
  logic [ADDR_W-1:0] start_q, start_d, end_q, end_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              on_q, on_d, en;

  assign hit        = on_q && (pc == end_q);
  assign more       = cnt_q > CNT_W'(1);
  assign start_addr = start_q;
  assign en         = wr_start | wr_end | wr_cnt | take;

  always_comb begin
    start_d = start_q;
    end_d   = end_q;
    cnt_d   = cnt_q;
    on_d    = on_q;
    if (wr_start) start_d = wdata;
    if (wr_end)   end_d   = wdata;
    if (wr_cnt) begin
      cnt_d = wdata[CNT_W-1:0];
      on_d  = |wdata[CNT_W-1:0];
    end else if (take) begin
      if (more) cnt_d = cnt_q - CNT_W'(1);
      else      on_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      end_q   <= '0;
      cnt_q   <= '0;
      on_q    <= 1'b0;
    end else if (en) begin
      start_q <= start_d;
      end_q   <= end_d;
      cnt_q   <= cnt_d;
      on_q    <= on_d;
    end
  end

  // R5: an acting entry with passes left loses exactly one count
  p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && more && !wr_cnt) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  // R6: the final pass retires the entry
  p_last_pass_retires_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !more && !wr_cnt) |=> !hit && !on_q);
  // R3: a zero count never arms the entry
  p_zero_count_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt && (wdata[CNT_W-1:0] == '0)) |=> !on_q);
endmodule

// File: rtl/hwloop_pick.sv
module hwloop_pick #(
  parameter int N_LOOPS = 2,
  parameter int ADDR_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      go,
  input  logic [N_LOOPS-1:0]        hit,
  input  logic [N_LOOPS-1:0]        more,
  input  logic [N_LOOPS*ADDR_W-1:0] starts,
  output logic [N_LOOPS-1:0]        take,
  output logic                      jump,
  output logic [ADDR_W-1:0]         target
);
  always_comb begin
    logic blocked;
    blocked = 1'b0;
    take    = '0;
    jump    = 1'b0;
    target  = '0;
    for (int i = 0; i < N_LOOPS; i++) begin
      if (go && hit[i] && !blocked) begin
        take[i] = 1'b1;
        if (more[i]) begin
          jump    = 1'b1;
          target  = starts[i*ADDR_W +: ADDR_W];
          blocked = 1'b1;
        end
      end
    end
  end

  // R8: at most one entry may redirect in a cycle
  p_single_jumper_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take & more));
endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl #(
  parameter int N_LOOPS = 2,
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 16,
  localparam int IDX_W  = (N_LOOPS > 1) ? $clog2(N_LOOPS) : 1
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_data,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic              fetch_stall,
  output logic              redir_valid,
  output logic [ADDR_W-1:0] redir_pc
);
  import hwloop_pkg::*;

  logic [1:0]                rst_sync_q;
  logic                      rst_n;
  logic [N_LOOPS-1:0]        hit, more, take;
  logic [N_LOOPS*ADDR_W-1:0] starts;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  for (genvar g = 0; g < N_LOOPS; g++) begin : g_entry
    logic sel_me;
    assign sel_me = cfg_we && (cfg_idx == IDX_W'(g));
    hwloop_entry #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_entry (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_start   (sel_me && (cfg_sel == LREG_START)),
      .wr_end     (sel_me && (cfg_sel == LREG_END)),
      .wr_cnt     (sel_me && (cfg_sel == LREG_COUNT)),
      .wdata      (cfg_data),
      .pc         (fetch_pc),
      .take       (take[g]),
      .hit        (hit[g]),
      .more       (more[g]),
      .start_addr (starts[g*ADDR_W +: ADDR_W])
    );
  end

  hwloop_pick #(.N_LOOPS(N_LOOPS), .ADDR_W(ADDR_W)) u_pick (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (!fetch_stall),
    .hit    (hit),
    .more   (more),
    .starts (starts),
    .take   (take),
    .jump   (redir_valid),
    .target (redir_pc)
  );

  // R7: a stalled fetch never receives a redirect
  p_no_redir_in_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stall |-> !redir_valid);
endmodule

// File: tb/hwloop_ctrl_bench.sv
module hwloop_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we = 1'b0;
  logic [0:0]    cfg_idx = '0;
  logic [1:0]    cfg_sel = '0;
  logic [AW-1:0] cfg_data = '0;
  logic [AW-1:0] fetch_pc = '0;
  logic          fetch_stall = 1'b0;
  logic          redir_valid;
  logic [AW-1:0] redir_pc;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hwloop_ctrl u_hwloop_ctrl (
    .clk(clk), .rst_ni(rst_ni), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data), .fetch_pc(fetch_pc),
    .fetch_stall(fetch_stall), .redir_valid(redir_valid), .redir_pc(redir_pc)
  );

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    cfg_we = 1'b0;
    fetch_stall = 1'b0;
    fetch_pc = '0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic cfg(input int idx, input int sel, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_idx = idx[0:0];
    cfg_sel = sel[1:0];
    cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input int idx, input logic [AW-1:0] s, input logic [AW-1:0] e, input logic [AW-1:0] n);
    cfg(idx, 0, s);
    cfg(idx, 1, e);
    cfg(idx, 2, n);
  endtask

  // Present one fetch cycle and check the combinational response before the edge.
  task automatic visit(input logic [AW-1:0] pc, input logic stall, input logic exp_v,
                       input logic [AW-1:0] exp_pc, input string tag);
    @(negedge clk);
    fetch_pc = pc;
    fetch_stall = stall;
    #1;
    checks++;
    if (redir_valid !== exp_v || (exp_v && redir_pc !== exp_pc)) begin
      errors++;
      $display("FAIL %s: pc=%h got valid=%b target=%h, expected valid=%b target=%h",
               tag, pc, redir_valid, redir_pc, exp_v, exp_pc);
    end
  endtask

  task automatic t_reset();
    do_reset();
    visit(32'h0, 1'b0, 1'b0, 32'h0, "R1 reset pc 0");
    visit(32'h0000_0100, 1'b0, 1'b0, 32'h0, "R1 reset pc 100");
  endtask

  task automatic t_basic_loop();
    do_reset();
    setup(0, 32'h100, 32'h10C, 32'd3);
    visit(32'h104, 1'b0, 1'b0, 32'h0, "R10 mid-body pc");
    visit(32'h10C, 1'b0, 1'b1, 32'h100, "R4 first end redirect");
    visit(32'h10C, 1'b0, 1'b1, 32'h100, "R5 second end redirect");
    visit(32'h10C, 1'b0, 1'b0, 32'h0, "R6 last pass falls through");
    visit(32'h10C, 1'b0, 1'b0, 32'h0, "R6 retired entry stays quiet");
  endtask

  task automatic t_inactive_setups();
    do_reset();
    cfg(1, 0, 32'h200);
    cfg(1, 1, 32'h210);
    visit(32'h210, 1'b0, 1'b0, 32'h0, "R2 addresses only, no count");
    cfg(1, 3, 32'd5);
    visit(32'h210, 1'b0, 1'b0, 32'h0, "R2 select 3 ignored");
    cfg(1, 2, 32'd0);
    visit(32'h210, 1'b0, 1'b0, 32'h0, "R3 zero count stays inactive");
  endtask

  task automatic t_stall();
    do_reset();
    setup(0, 32'h400, 32'h408, 32'd2);
    visit(32'h408, 1'b1, 1'b0, 32'h0, "R7 stalled end no redirect");
    visit(32'h408, 1'b1, 1'b0, 32'h0, "R7 second stalled cycle");
    visit(32'h408, 1'b0, 1'b1, 32'h400, "R7 count kept through stall");
    visit(32'h408, 1'b0, 1'b0, 32'h0, "R5 two passes only");
  endtask

  task automatic t_nested_shared_end();
    do_reset();
    setup(0, 32'h300, 32'h320, 32'd2);
    setup(1, 32'h2F0, 32'h320, 32'd2);
    visit(32'h320, 1'b0, 1'b1, 32'h300, "R8 inner entry wins");
    visit(32'h320, 1'b0, 1'b1, 32'h2F0, "R9 outer redirects as inner retires");
    visit(32'h320, 1'b0, 1'b0, 32'h0, "R8 outer count untouched earlier, now done");
  endtask

  initial begin
    t_reset();
    t_basic_loop();
    t_inactive_setups();
    t_stall();
    t_nested_shared_end();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule